// File: doc/BRIEF.md
# Fixed-Point 5x5 Gaussian Blur Core

The core turns one 5x5 neighbourhood of unsigned 8-bit grayscale pixels into one smoothed output pixel. The 25 pixels arrive together on a single wide input. The core multiplies each by a constant integer weight. The weights are a Gaussian of spread 5 scaled so that they total 4096. The 25 products are reduced in a registered binary adder tree. The sum is then scaled back down by 4096 with round-to-nearest, and the pixel leaves with a one-cycle valid pulse.

A surrounding scan controller walks the interior of an image (for a 256x256 picture, the 252x252 centres whose full window lies inside the frame) and offers one window at a time. The input follows valid/ready rules. The core raises `in_ready` only while idle, and a window transfers on a rising edge where `in_valid` and `in_ready` are both high. The sender may hold `in_valid` and change `in_window` freely while `in_ready` is low, and nothing is taken. The output has no back-pressure. The consumer must take `out_pixel` in the single cycle that `out_valid` is high. Holding `in_valid` continuously gives one result every 6 cycles.

Top module: `gauss5x5_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` is 0 and `in_ready` is 1.
- R2: A window is taken only on a rising edge with `in_valid` and `in_ready` both high; from the next cycle `in_ready` stays low until the result cycle.
- R3: `out_valid` rises on the sixth rising edge counting the accepting edge as the first.
- R4: Each accepted window yields exactly one `out_valid` cycle, never two consecutive ones.
- R5: A window offered while `in_ready` is low is ignored: it produces no result and does not alter the result in flight.
- R6: `in_ready` is high in the cycle where `out_valid` is high, so with `in_valid` held a new window is accepted every 6 cycles.
- R7: Pixel (row r, column c), r and c in 0..4 with row 0 on top, sits at `in_window[8*(5r+c)+7 : 8*(5r+c)]`. Its weight depends on the distances (a,b) from the centre, with a <= b: (0,0)=180, (0,1)=174, (0,2)=164, (1,1)=170, (1,2)=160, (2,2)=151. The weights total 4096.
- R8: `out_pixel` = floor((sum of weight*pixel + 2048) / 4096), clamped to 255.
- R9: A window whose 25 pixels all equal v returns exactly v.
- R10: A reset while a window is in flight discards it: no `out_valid` follows for that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window offered |
| in_ready | output | 1 | Core idle and able to take a window |
| in_window | input | 200 | 25 packed 8-bit pixels, row-major |
| out_valid | output | 1 | One-cycle result strobe |
| out_pixel | output | 8 | Filtered pixel, valid with `out_valid` |

## Verification
The hardest situation to reach from the ports is a sender that keeps offering a different window while the core is busy. The offer must end exactly before the result cycle, where `in_ready` returns. Otherwise a rejected offer cannot be told apart from a real transfer. The stimulus lands on the accepting edge, keeps a second window on the bus for the next three busy cycles, and withdraws it before the result. The scoreboard then demands one output carrying the first window's value. A reset injected two cycles into a computation is covered the same way, with an empty scoreboard that flags any late strobe.

// File: rtl/gauss_pkg.sv
package gauss_pkg;
  localparam int KDIM     = 5;
  localparam int NTAP     = KDIM * KDIM;
  localparam int SCALE_SH = 12;
  localparam int WGT_W    = 8;

  // integer weight of tap idx (row-major), symmetric in distance from centre
  function automatic int tap_weight(int idx);
    int r, c, dr, dc, lo, hi, w;
    r  = idx / KDIM;
    c  = idx % KDIM;
    dr = (r > KDIM / 2) ? r - KDIM / 2 : KDIM / 2 - r;
    dc = (c > KDIM / 2) ? c - KDIM / 2 : KDIM / 2 - c;
    lo = (dr < dc) ? dr : dc;
    hi = (dr < dc) ? dc : dr;
    case (lo * 4 + hi)
      0:       w = 180;
      1:       w = 174;
      2:       w = 164;
      5:       w = 170;
      6:       w = 160;
      default: w = 151;
    endcase
    return w;
  endfunction

  // number of nodes at tree level l for n leaves
  function automatic int level_count(int n, int l);
    return (n + (1 << l) - 1) >> l;
  endfunction

  // start of level l in a flat node array holding levels 1..
  function automatic int level_offset(int n, int l);
    int off;
    off = 0;
    for (int k = 1; k < l; k++) off += level_count(n, k);
    return off;
  endfunction
endpackage

// File: rtl/gauss_products.sv
module gauss_products
  import gauss_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int PROD_W = PIX_W + WGT_W
) (
  input  logic                     clk,
  input  logic                     en_i,
  input  logic [NTAP*PIX_W-1:0]    win_i,
  output logic [PROD_W-1:0]        prod_o [NTAP]
);
  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    localparam logic [WGT_W-1:0] WT = WGT_W'(tap_weight(i));
    logic [PIX_W-1:0] pix;
    assign pix = win_i[i*PIX_W +: PIX_W];
    always_ff @(posedge clk) begin
      if (en_i) prod_o[i] <= PROD_W'(pix) * PROD_W'(WT);
    end
  end
endmodule

// File: rtl/gauss_add_tree.sv
module gauss_add_tree
  import gauss_pkg::*;
#(
  parameter int NT = NTAP,
  parameter int W  = 21
) (
  input  logic         clk,
  input  logic [W-1:0] term_i [NT],
  output logic [W-1:0] sum_o
);
  localparam int LV    = $clog2(NT);
  localparam int NODES = level_offset(NT, LV);
  localparam int LOFF  = level_offset(NT, LV - 1);
  localparam int LCNT  = level_count(NT, LV - 1);

  logic [W-1:0] node [NODES];

  // registered levels 1 .. LV-1
  for (genvar l = 1; l < LV; l++) begin : g_lvl
    localparam int PREV = level_count(NT, l - 1);
    localparam int SRC  = (l == 1) ? 0 : level_offset(NT, l - 1);
    for (genvar i = 0; i < level_count(NT, l); i++) begin : g_node
      localparam int DST = level_offset(NT, l) + i;
      if (l == 1) begin : g_leaf
        if (2 * i + 1 < PREV) begin : g_pair
          always_ff @(posedge clk) node[DST] <= term_i[2*i] + term_i[2*i+1];
        end else begin : g_pass
          always_ff @(posedge clk) node[DST] <= term_i[2*i];
        end
      end else begin : g_inner
        if (2 * i + 1 < PREV) begin : g_pair
          always_ff @(posedge clk) node[DST] <= node[SRC+2*i] + node[SRC+2*i+1];
        end else begin : g_pass
          always_ff @(posedge clk) node[DST] <= node[SRC+2*i];
        end
      end
    end
  end

  // last level is combinational; the caller registers it
  if (LCNT == 2) begin : g_final_pair
    assign sum_o = node[LOFF] + node[LOFF+1];
  end else begin : g_final_pass
    assign sum_o = node[LOFF];
  end
endmodule

// File: rtl/gauss_round_sat.sv
module gauss_round_sat #(
  parameter int ACC_W = 21,
  parameter int SH    = 12,
  parameter int PIX_W = 8
) (
  input  logic [ACC_W-1:0] sum_i,
  output logic [PIX_W-1:0] pix_o
);
  localparam int QW = ACC_W + 1 - SH;
  localparam logic [ACC_W:0] HALF = (ACC_W+1)'(2 ** (SH - 1));
  localparam logic [QW-1:0]  MAXV = QW'(2 ** PIX_W - 1);

  logic [ACC_W:0] biased;
  logic [QW-1:0]  quot;

  always_comb begin
    biased = {1'b0, sum_i} + HALF;
    quot   = biased[ACC_W:SH];
    pix_o  = (quot > MAXV) ? MAXV[PIX_W-1:0] : quot[PIX_W-1:0];
  end
endmodule

// File: rtl/gauss5x5_core.sv
module gauss5x5_core
  import gauss_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int GUARD_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [NTAP*PIX_W-1:0] in_window,
  output logic                  out_valid,
  output logic [PIX_W-1:0]      out_pixel
);
  localparam int PROD_W = PIX_W + WGT_W;
  localparam int ACC_W  = PROD_W + GUARD_W;
  localparam int LV     = $clog2(NTAP);

  logic              busy;
  logic              accept;
  logic [LV-1:0]     vld;
  logic [PROD_W-1:0] prod [NTAP];
  logic [ACC_W-1:0]  terms [NTAP];
  logic [ACC_W-1:0]  total;
  logic [PIX_W-1:0]  rounded;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  gauss_products #(.PIX_W(PIX_W), .PROD_W(PROD_W)) u_prod (
    .clk(clk), .en_i(accept), .win_i(in_window), .prod_o(prod)
  );

  for (genvar i = 0; i < NTAP; i++) begin : g_ext
    assign terms[i] = ACC_W'(prod[i]);
  end

  gauss_add_tree #(.NT(NTAP), .W(ACC_W)) u_tree (
    .clk(clk), .term_i(terms), .sum_o(total)
  );

  gauss_round_sat #(.ACC_W(ACC_W), .SH(SCALE_SH), .PIX_W(PIX_W)) u_round (
    .sum_i(total), .pix_o(rounded)
  );

  // valid bit travelling beside the product register and tree levels
  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[LV-2:0], accept};
  end

  always_ff @(posedge clk) begin
    if (rst)                 busy <= 1'b0;
    else if (accept)         busy <= 1'b1;
    else if (vld[LV-1])      busy <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pixel <= '0;
    end else begin
      out_valid <= vld[LV-1];
      if (vld[LV-1]) out_pixel <= rounded;
    end
  end

  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> ##5 out_valid);

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_only_from_accept_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready, 6));

  assert_ready_at_result_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_ready);
endmodule

// File: tb/tb_gauss5x5_core.sv
module tb_gauss5x5_core;
  localparam int CLK_P = 10;
  localparam int WB    = 200;

  typedef struct {
    logic [7:0] val;
    int         due;
    string      tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [WB-1:0] in_window = '0;
  logic          out_valid;
  logic [7:0]    out_pixel;

  int   nchk = 0;
  int   nerr = 0;
  int   cyc  = 0;
  int   last_acc = 0;
  bit   prev_ov = 1'b0;
  bit   ended = 1'b0;
  exp_t q [$];

  gauss5x5_core dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_window(in_window), .out_valid(out_valid), .out_pixel(out_pixel)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ref_w(int r, int c);
    int dr, dc, lo, hi;
    dr = (r > 2) ? r - 2 : 2 - r;
    dc = (c > 2) ? c - 2 : 2 - c;
    lo = (dr < dc) ? dr : dc;
    hi = (dr < dc) ? dc : dr;
    if (lo == 0 && hi == 0) return 180;
    if (lo == 0 && hi == 1) return 174;
    if (lo == 0 && hi == 2) return 164;
    if (lo == 1 && hi == 1) return 170;
    if (lo == 1 && hi == 2) return 160;
    return 151;
  endfunction

  function automatic logic [7:0] ref_pix(logic [WB-1:0] w);
    int acc;
    acc = 0;
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < 5; c++)
        acc += int'(w[8*(5*r+c) +: 8]) * ref_w(r, c);
    acc = (acc + 2048) >> 12;
    if (acc > 255) acc = 255;
    return acc[7:0];
  endfunction

  function automatic logic [WB-1:0] uniform(logic [7:0] v);
    logic [WB-1:0] w;
    for (int i = 0; i < 25; i++) w[8*i +: 8] = v;
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // driver: called at a falling edge, returns at a falling edge
  task automatic drive(input logic [WB-1:0] w, input string tag, input bit keep, input bit gap_chk);
    exp_t e;
    in_window = w;
    in_valid  = 1'b1;
    while (!in_ready) @(negedge clk);
    e.val = ref_pix(w);
    e.due = cyc + 6;
    e.tag = tag;
    q.push_back(e);
    if (gap_chk) check(cyc - last_acc == 6, "R6 window spacing", cyc - last_acc, 6);
    last_acc = cyc;
    @(negedge clk);
    check(in_ready == 1'b0, "R2 busy after accept", in_ready, 0);
    if (!keep) in_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    if (!rst) begin
      if (prev_ov) check(out_valid == 1'b0, "R4 pulse width", out_valid, 0);
      if (out_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R5/R10 unexpected result", 1, 0);
        end else begin
          e = q.pop_front();
          check(out_pixel == e.val, e.tag, out_pixel, e.val);
          check(cyc == e.due, "R3 latency", cyc, e.due);
        end
      end
    end
    prev_ov = out_valid && !rst;
  end

  task automatic finish_sim();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    check(1'b0, "watchdog expired", 0, 1);
    finish_sim();
  end

  initial begin
    logic [WB-1:0] w;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 state during reset", {out_valid, in_ready}, 1);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 state after reset", {out_valid, in_ready}, 1);

    // R9 uniform windows
    drive(uniform(8'd0),   "R9 uniform 0",   1'b0, 1'b0);
    drive(uniform(8'd1),   "R9 uniform 1",   1'b0, 1'b0);
    drive(uniform(8'd128), "R9 uniform 128", 1'b0, 1'b0);
    drive(uniform(8'd255), "R9 uniform 255", 1'b0, 1'b0);
    drive(uniform(8'd77),  "R9 uniform 77",  1'b0, 1'b0);

    // R7 impulse at every tap checks weight and position
    for (int i = 0; i < 25; i++) begin
      w = '0;
      w[8*i +: 8] = 8'd255;
      drive(w, "R7 impulse weight", 1'b0, 1'b0);
    end

    // R8 arbitrary windows, including idle gaps
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < 25; i++) w[8*i +: 8] = 8'($urandom);
      drive(w, "R8 random window", 1'b0, 1'b0);
      repeat (k % 3) @(negedge clk);
    end

    // R6 continuous stream with in_valid held
    for (int k = 0; k < 10; k++) begin
      for (int i = 0; i < 25; i++) w[8*i +: 8] = 8'($urandom);
      drive(w, "R8 streamed window", k < 9, k > 0);
    end

    // R5 offer while busy: must be ignored
    drive(uniform(8'd40), "R5 in-flight result", 1'b0, 1'b0);
    in_window = uniform(8'd200);
    in_valid  = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R5 ready low while offering", in_ready, 0);
    end
    in_valid = 1'b0;
    repeat (8) @(negedge clk);
    check(q.size() == 0, "R5 no extra result", q.size(), 0);

    // R10 reset in flight
    in_window = uniform(8'd99);
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R10 reset mid-flight", {out_valid, in_ready}, 1);
    rst = 1'b0;
    repeat (10) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R10 no late result", out_valid, 0);
    end

    // final drain
    repeat (20) @(negedge clk);
    check(q.size() == 0, "R4 one result per window", q.size(), 0);
    finish_sim();
  end
endmodule